// File: doc/BRIEF.md
# Range-Line Offset Removal and Zero-Fill Unit

This unit sits in front of a power-of-two FFT in a radar range processor. It takes one range line of raw complex samples at a time over a valid/ready stream, with a marker on the first sample of each line. Each sample carries a signed 8-bit in-phase part and a signed 8-bit quadrature part. The whole line is stored, and the in-phase and quadrature parts are summed separately. Each sum is then divided by the line length, rounded to the nearest integer, to give the DC offset of that component.

On a second pass the stored line is read out with the offset subtracted from every sample. Each result saturates to the signed 8-bit range. The real samples are followed by zeros until the frame reaches its power-of-two length, so the transform behind it always sees a fixed frame size. Once a frame starts, the output moves one sample per clock with no gaps, because the transform takes a new sample every cycle. A marker flags the final sample of each frame.

Defaults are 5,616 real samples per line and 8,192 samples per output frame. The division is a fixed reciprocal multiply, sized so that it gives the exact rounded quotient for every possible sum.

Top module: `rline_dc_pad`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_last` are 0. Asserting `rst_n` low drops them at once and abandons any partial line or frame. Within four cycles after release, `in_ready` is 1 and `out_valid` is 0.
- R2: A line begins only when a sample is accepted (`in_valid` and `in_ready` both 1) with `in_sop` = 1, and that sample is index 0. Samples accepted with `in_sop` = 0 while no line is open are discarded and have no effect on any later frame.
- R3: A sample accepted with `in_sop` = 1 in the middle of a line discards the partial line and starts a new one at index 0.
- R4: When the 5,616th sample (index 5,615) of a line is accepted, `in_ready` goes to 0 and stays 0 at least until the first sample of that frame is presented.
- R5: Each component's offset is its sum over the 5,616 real samples divided by 5,616 and rounded to the nearest integer, with exact halves rounded away from zero. Output sample k, for k below 5,616, is the stored sample k minus that offset, computed separately for I and Q in two's complement.
- R6: A corrected value above 127 is output as 127, and one below -128 is output as -128.
- R7: Output samples 5,616 to 8,191 of every frame are 0 on both `out_i` and `out_q`.
- R8: A frame is presented as exactly 8,192 samples, with `out_valid` high on consecutive cycles and no gap.
- R9: `out_last` is 1 on output sample 8,191 of each frame and on no other sample.
- R10: `out_valid` rises exactly three clock cycles after the edge that accepts the final real sample of a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample is present |
| in_ready | output | 1 | Unit can take an input sample this cycle |
| in_sop | input | 1 | Marks sample index 0 of a line |
| in_i | input | 8 | In-phase part, signed |
| in_q | input | 8 | Quadrature part, signed |
| out_valid | output | 1 | Output sample is present |
| out_last | output | 1 | Marks the final sample of a frame |
| out_i | output | 8 | Corrected in-phase part, signed |
| out_q | output | 8 | Corrected quadrature part, signed |

## Verification
Two functions can fall in the same cycle. While the zero tail of one frame and its last marker are still coming out, the unit is already taking in the opening samples of the next line, including the start marker. The bench provokes this by driving table rows back to back, so each new line is offered on the first cycle `in_ready` comes back. The outgoing frame is judged on its zero padding, its run length and the position of its marker. The incoming frame is judged on its corrected data and its start latency, which would both be wrong if the overlap had dropped or mixed up samples.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

  // Default sample width of one complex component.
  localparam int DCP_SAMPLE_W = 8;

  // Operating phase of the unit.
  typedef enum logic [1:0] {
    PH_FILL = 2'd0,  // taking in a line, summing components
    PH_MEAN = 2'd1,  // capturing the rounded offsets
    PH_EMIT = 2'd2   // streaming corrected samples and zero fill
  } phase_e;

endpackage

// File: rtl/dcp_lane_acc.sv
// Running sum of one component over a line.
module dcp_lane_acc #(
  parameter int DW    = 8,
  parameter int SUM_W = 22
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_en,
  input  logic                    add_en,
  input  logic signed [DW-1:0]    sample,
  output logic signed [SUM_W-1:0] sum
);

  logic signed [SUM_W-1:0] ext;
  logic signed [SUM_W-1:0] sum_d;
  logic signed [SUM_W-1:0] sum_q;
  logic                    acc_en;

  always_comb begin
    ext    = SUM_W'(sample);
    acc_en = load_en | add_en;
    sum_d  = load_en ? ext : (sum_q + ext);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (acc_en) begin
      sum_q <= sum_d;
    end
  end

  assign sum = sum_q;

endmodule

// File: rtl/dcp_mean_div.sv
// Rounded division of a signed line sum by the line length, using a
// reciprocal multiply wide enough to give the exact quotient.
module dcp_mean_div #(
  parameter int SUM_W    = 22,
  parameter int LINE_LEN = 5616,
  parameter int MW       = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_en,
  input  logic signed [SUM_W-1:0] sum,
  output logic signed [MW-1:0]    mean
);

  localparam int          XW    = SUM_W;
  localparam int          NW    = $clog2(LINE_LEN) + 1;
  localparam int          SH    = XW + NW;
  localparam logic [63:0] RECIP = ((64'd1 << SH) + 64'(LINE_LEN) - 64'd1) / 64'(LINE_LEN);
  localparam logic [XW-1:0] HALF = XW'(LINE_LEN / 2);

  logic                 neg;
  logic [XW-1:0]        mag;
  logic [XW-1:0]        biased;
  logic [63:0]          prod;
  logic [63:0]          quo;
  logic signed [MW-1:0] qmag;
  logic signed [MW-1:0] mean_d;
  logic signed [MW-1:0] mean_q;

  always_comb begin
    neg    = sum[SUM_W-1];
    mag    = neg ? XW'(-sum) : XW'(sum);
    biased = mag + HALF;
    prod   = 64'(biased) * RECIP;
    quo    = prod >> SH;
    qmag   = MW'(quo);
    mean_d = neg ? -qmag : qmag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mean_q <= '0;
    end else if (cap_en) begin
      mean_q <= mean_d;
    end
  end

  assign mean = mean_q;

endmodule

// File: rtl/dcp_linebuf.sv
// Single-port-write, registered-read line store.
module dcp_linebuf #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 5616,
  parameter int AW    = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= mem[rd_addr];
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/dcp_lane_out.sv
// Offset subtraction with saturation, or zero fill, for one component.
module dcp_lane_out #(
  parameter int DW = 8,
  parameter int MW = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld,
  input  logic                 pad,
  input  logic signed [DW-1:0] raw,
  input  logic signed [MW-1:0] mean,
  output logic signed [DW-1:0] res
);

  localparam int                   XW = MW + 1;
  localparam logic signed [XW-1:0] HI = XW'((2 ** (DW - 1)) - 1);
  localparam logic signed [XW-1:0] LO = XW'(-(2 ** (DW - 1)));

  logic signed [XW-1:0] diff;
  logic signed [DW-1:0] clamped;
  logic signed [DW-1:0] res_d;
  logic signed [DW-1:0] res_q;

  always_comb begin
    diff = XW'(raw) - XW'(mean);
    if (diff > HI) begin
      clamped = HI[DW-1:0];
    end else if (diff < LO) begin
      clamped = LO[DW-1:0];
    end else begin
      clamped = diff[DW-1:0];
    end
    res_d = (vld && !pad) ? clamped : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else begin
      res_q <= res_d;
    end
  end

  assign res = res_q;

endmodule

// File: rtl/rline_dc_pad.sv
// Per-line DC offset removal followed by zero fill to a power-of-two frame.
module rline_dc_pad
  import dcp_pkg::*;
#(
  parameter int DW        = DCP_SAMPLE_W,
  parameter int LINE_LEN  = 5616,
  parameter int FRAME_LEN = 8192
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_sop,
  input  logic [DW-1:0] in_i,
  input  logic [DW-1:0] in_q,
  output logic          out_valid,
  output logic          out_last,
  output logic [DW-1:0] out_i,
  output logic [DW-1:0] out_q
);

  localparam int LANES = 2;
  localparam int LAW   = $clog2(LINE_LEN);
  localparam int FAW   = $clog2(FRAME_LEN);
  localparam int SUM_W = DW + $clog2(LINE_LEN) + 1;
  localparam int MW    = DW + 1;
  localparam int BW    = LANES * DW;

  localparam logic [LAW-1:0] LAST_WR  = LAW'(LINE_LEN - 1);
  localparam logic [FAW-1:0] LAST_OUT = FAW'(FRAME_LEN - 1);
  localparam logic [FAW-1:0] REAL_END = FAW'(LINE_LEN);

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_sn = rst_pipe[1];

  // Control state.
  phase_e         state_q, state_d;
  logic [LAW-1:0] wr_cnt_q, wr_cnt_d;
  logic           in_line_q, in_line_d;
  logic [FAW-1:0] emit_cnt_q, emit_cnt_d;

  logic           accept;
  logic           take_sop;
  logic           take_cont;
  logic           take;
  logic [LAW-1:0] wr_addr;
  logic           last_in;
  logic           emitting;
  logic           rd_en;
  logic [LAW-1:0] rd_addr;

  always_comb begin
    in_ready  = (state_q == PH_FILL);
    accept    = in_valid & in_ready;
    take_sop  = accept & in_sop;
    take_cont = accept & ~in_sop & in_line_q;
    take      = take_sop | take_cont;
    wr_addr   = take_sop ? '0 : wr_cnt_q;
    last_in   = take && (wr_addr == LAST_WR);
    emitting  = (state_q == PH_EMIT);
    rd_en     = emitting && (emit_cnt_q < REAL_END);
    rd_addr   = LAW'(emit_cnt_q);
  end

  always_comb begin
    state_d    = state_q;
    wr_cnt_d   = wr_cnt_q;
    in_line_d  = in_line_q;
    emit_cnt_d = emit_cnt_q;
    unique case (state_q)
      PH_FILL: begin
        if (take_sop) begin
          wr_cnt_d  = LAW'(1);
          in_line_d = 1'b1;
        end else if (take_cont) begin
          wr_cnt_d = wr_cnt_q + 1'b1;
        end
        if (last_in) begin
          state_d   = PH_MEAN;
          wr_cnt_d  = '0;
          in_line_d = 1'b0;
        end
      end
      PH_MEAN: begin
        state_d    = PH_EMIT;
        emit_cnt_d = '0;
      end
      PH_EMIT: begin
        emit_cnt_d = emit_cnt_q + 1'b1;
        if (emit_cnt_q == LAST_OUT) begin
          state_d = PH_FILL;
        end
      end
      default: begin
        state_d = PH_FILL;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q    <= PH_FILL;
      wr_cnt_q   <= '0;
      in_line_q  <= 1'b0;
      emit_cnt_q <= '0;
    end else begin
      state_q    <= state_d;
      wr_cnt_q   <= wr_cnt_d;
      in_line_q  <= in_line_d;
      emit_cnt_q <= emit_cnt_d;
    end
  end

  // Line store holds both components side by side.
  logic [BW-1:0] wr_word;
  logic [BW-1:0] rd_word;

  assign wr_word = {in_q, in_i};

  dcp_linebuf #(
    .WIDTH(BW),
    .DEPTH(LINE_LEN),
    .AW   (LAW)
  ) u_buf (
    .clk    (clk),
    .rst_n  (rst_sn),
    .wr_en  (take),
    .wr_addr(wr_addr),
    .wr_data(wr_word),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .rd_data(rd_word)
  );

  // Read-side pipeline: stage A aligns with the store read, stage B with the result.
  logic a_vld_q, a_pad_q, a_last_q;
  logic a_vld_d, a_pad_d, a_last_d;
  logic b_vld_q, b_last_q;

  always_comb begin
    a_vld_d  = emitting;
    a_pad_d  = emitting && (emit_cnt_q >= REAL_END);
    a_last_d = emitting && (emit_cnt_q == LAST_OUT);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      a_vld_q  <= 1'b0;
      a_pad_q  <= 1'b0;
      a_last_q <= 1'b0;
      b_vld_q  <= 1'b0;
      b_last_q <= 1'b0;
    end else begin
      a_vld_q  <= a_vld_d;
      a_pad_q  <= a_pad_d;
      a_last_q <= a_last_d;
      b_vld_q  <= a_vld_q;
      b_last_q <= a_last_q;
    end
  end

  // One datapath per component.
  logic [DW-1:0] lane_in  [LANES];
  logic [DW-1:0] lane_res [LANES];

  assign lane_in[0] = in_i;
  assign lane_in[1] = in_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [SUM_W-1:0] sum;
    logic signed [MW-1:0]    mean;
    logic signed [DW-1:0]    res;

    dcp_lane_acc #(
      .DW   (DW),
      .SUM_W(SUM_W)
    ) u_acc (
      .clk    (clk),
      .rst_n  (rst_sn),
      .load_en(take_sop),
      .add_en (take_cont),
      .sample (lane_in[g]),
      .sum    (sum)
    );

    dcp_mean_div #(
      .SUM_W   (SUM_W),
      .LINE_LEN(LINE_LEN),
      .MW      (MW)
    ) u_div (
      .clk   (clk),
      .rst_n (rst_sn),
      .cap_en(state_q == PH_MEAN),
      .sum   (sum),
      .mean  (mean)
    );

    dcp_lane_out #(
      .DW(DW),
      .MW(MW)
    ) u_out (
      .clk  (clk),
      .rst_n(rst_sn),
      .vld  (a_vld_q),
      .pad  (a_pad_q),
      .raw  (rd_word[g*DW +: DW]),
      .mean (mean),
      .res  (res)
    );

    assign lane_res[g] = res;
  end

  assign out_valid = b_vld_q;
  assign out_last  = b_last_q;
  assign out_i     = lane_res[0];
  assign out_q     = lane_res[1];

endmodule

// File: rtl/rline_dc_pad_chk.sv
// Property checker for the offset removal unit, attached by bind.
module rline_dc_pad_chk #(
  parameter int DW        = 8,
  parameter int LINE_LEN  = 5616,
  parameter int FRAME_LEN = 8192
) (
  input logic          clk,
  input logic          rst_sn,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_last,
  input logic [DW-1:0] out_i,
  input logic [DW-1:0] out_q
);

  localparam int             FAW      = $clog2(FRAME_LEN);
  localparam logic [FAW-1:0] LAST_OUT = FAW'(FRAME_LEN - 1);
  localparam logic [FAW-1:0] REAL_END = FAW'(LINE_LEN);

  // Index of the sample currently presented within its frame.
  logic [FAW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      run_q <= '0;
    end else if (out_valid) begin
      run_q <= out_last ? '0 : (run_q + 1'b1);
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_sn |-> (!out_valid && !out_last));

  a_r4_ready_low_at_start: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(out_valid) |-> !in_ready);

  a_r10_start_latency: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(in_ready) |-> ##3 $rose(out_valid));

  a_r9_last_only_valid: assert property (@(posedge clk) disable iff (!rst_sn)
    out_last |-> out_valid);

  a_r9_last_position: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_valid && out_last) |-> (run_q == LAST_OUT));

  a_r8_no_gap: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_valid && !out_last) |=> out_valid);

  a_r7_pad_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_valid && (run_q >= REAL_END)) |-> (out_i == '0 && out_q == '0));

endmodule

bind rline_dc_pad rline_dc_pad_chk #(
  .DW       (DW),
  .LINE_LEN (LINE_LEN),
  .FRAME_LEN(FRAME_LEN)
) u_chk (
  .clk      (clk),
  .rst_sn   (rst_sn),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_last (out_last),
  .out_i    (out_i),
  .out_q    (out_q)
);

// File: tb/tb_rline_dc_pad.sv
`timescale 1ns/1ps
module tb_rline_dc_pad;

  localparam int N = 5616;
  localparam int F = 8192;

  typedef struct packed {
    logic [1:0]        mode;
    logic signed [7:0] a;
    logic signed [7:0] b;
    logic [3:0]        req;   // requirement number the row targets
  } vec_t;

  // mode 0: constant, 1: ramp, 2: split halves / single odd sample, 3: scrambled
  localparam vec_t VECS [6] = '{
    '{2'd0,  8'sd10, -8'sd20, 4'd5},
    '{2'd1,   8'sd5,   8'sd7, 4'd5},
    '{2'd2, 8'sd127, -8'sd128, 4'd6},
    '{2'd2,   8'sd1,   8'sd0, 4'd5},
    '{2'd2,  -8'sd1,   8'sd0, 4'd5},
    '{2'd3,   8'sd3,   8'sd9, 4'd5}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_sop;
  logic [7:0] in_i, in_q;
  logic       in_ready, out_valid, out_last;
  logic [7:0] out_i, out_q;

  always #4 clk = ~clk;

  rline_dc_pad dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop),
    .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_last(out_last),
    .out_i(out_i), .out_q(out_q)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input int req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int gen(input int mode, input int a, input int b,
                             input int idx, input int lane);
    int v;
    case (mode)
      0:       v = (lane == 0) ? a : b;
      1:       v = (lane == 0) ? (a + idx) : (b - 3 * idx);
      2:       v = (lane == 0) ? ((idx < N / 2) ? a : b) : ((idx == 0) ? a : b);
      default: v = (lane == 0) ? ((idx * 37 + a) ^ (idx >> 3)) : ((idx * 101 + b) ^ (idx >> 5));
    endcase
    return int'($signed(v[7:0]));
  endfunction

  function automatic int mean_of(input int mode, input int a, input int b, input int lane);
    int s = 0;
    for (int k = 0; k < N; k++) s += gen(mode, a, b, k, lane);
    if (s >= 0) return (s + N / 2) / N;
    return -((-s + N / 2) / N);
  endfunction

  function automatic int clamp8(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  // Expected frames, in order of line start.
  int fr_mode [16];
  int fr_a    [16];
  int fr_b    [16];
  int fr_req  [16];
  int nf   = 0;
  int fcnt = 0;

  // Output monitor.
  int oidx = 0;
  int m_i, m_q, errs, perr, bad_act, bad_exp, lat, rdy_at_start;
  int t_fall = 0;
  bit gap = 0;
  bit prev_rdy = 1'b1;

  always @(negedge clk) begin
    if (!rst_n) begin
      oidx = 0; fcnt = nf; gap = 0; prev_rdy = in_ready;
    end else begin
      if (prev_rdy && !in_ready) t_fall = cyc;
      prev_rdy = in_ready;
      if (out_valid) begin
        int ei, eq;
        if (oidx == 0) begin
          m_i = mean_of(fr_mode[fcnt], fr_a[fcnt], fr_b[fcnt], 0);
          m_q = mean_of(fr_mode[fcnt], fr_a[fcnt], fr_b[fcnt], 1);
          errs = 0; perr = 0; gap = 0; bad_act = 0; bad_exp = 0;
          lat = cyc - t_fall;
          rdy_at_start = int'(in_ready);
        end
        if (oidx < N) begin
          ei = clamp8(gen(fr_mode[fcnt], fr_a[fcnt], fr_b[fcnt], oidx, 0) - m_i);
          eq = clamp8(gen(fr_mode[fcnt], fr_a[fcnt], fr_b[fcnt], oidx, 1) - m_q);
          if (int'($signed(out_i)) != ei || int'($signed(out_q)) != eq) begin
            if (errs == 0) begin
              bad_act = int'($signed(out_i)) * 1000 + int'($signed(out_q));
              bad_exp = ei * 1000 + eq;
            end
            errs++;
          end
        end else if (out_i != 8'd0 || out_q != 8'd0) begin
          perr++;
        end
        if (out_last || oidx == F - 1) begin
          // R5 / R6 (and R2 / R3 for the directed lines): corrected real samples
          check(errs == 0, fr_req[fcnt], "corrected samples (I*1000+Q)", bad_act, bad_exp);
          check(perr == 0, 7, "nonzero fill samples", perr, 0);                 // R7
          check(out_last && oidx == F - 1, 9, "index of last marker", oidx, F - 1); // R9
          check(!gap, 8, "gap inside frame", int'(gap), 0);                     // R8
          check(lat == 3, 10, "start latency", lat, 3);                         // R10
          check(rdy_at_start == 0, 4, "in_ready at frame start", rdy_at_start, 0); // R4
          oidx = 0;
          fcnt++;
        end else begin
          oidx++;
        end
      end else if (oidx != 0) begin
        gap = 1'b1;
      end
    end
  end

  // Input driving.
  task automatic push(input int vi, input int vq, input bit sop);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_sop   = sop;
    in_i     = vi[7:0];
    in_q     = vq[7:0];
  endtask

  task automatic idle_in();
    @(negedge clk);
    in_valid = 1'b0;
    in_sop   = 1'b0;
  endtask

  task automatic send_line(input int mode, input int a, input int b, input int req);
    fr_mode[nf] = mode; fr_a[nf] = a; fr_b[nf] = b; fr_req[nf] = req;
    nf++;
    for (int k = 0; k < N; k++)
      push(gen(mode, a, b, k, 0), gen(mode, a, b, k, 1), k == 0);
    idle_in();
  endtask

  // Watchdog: a hung run counts as a failed check.
  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d frames", fcnt, nf);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_i = '0; in_q = '0;
    repeat (3) @(negedge clk);
    check(!out_valid && !out_last, 1, "outputs during reset", int'(out_valid), 0); // R1
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(in_ready, 1, "in_ready after reset", int'(in_ready), 1);                 // R1
    check(!out_valid, 1, "out_valid after reset", int'(out_valid), 0);             // R1

    // Table rows driven back to back: tail of each frame overlaps the next fill.
    for (int r = 0; r < 6; r++)
      send_line(int'(VECS[r].mode), int'(VECS[r].a), int'(VECS[r].b), int'(VECS[r].req));

    // R2: samples without a start marker while no line is open are dropped.
    for (int k = 0; k < 50; k++) push(100, 100, 1'b0);
    send_line(0, -5, 6, 2);

    // R3: a start marker mid-line restarts the line.
    for (int k = 0; k < 300; k++) push(gen(0, 90, -90, k, 0), gen(0, 90, -90, k, 1), k == 0);
    send_line(1, -20, 33, 3);

    // R1: reset in the middle of an emitted frame.
    send_line(0, 40, 40, 1);
    while (!out_valid) @(negedge clk);
    repeat (100) @(negedge clk);
    #1 rst_n = 1'b0;
    @(negedge clk);
    check(!out_valid && !out_last, 1, "outputs after mid-frame reset", int'(out_valid), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(in_ready, 1, "in_ready after mid-frame reset", int'(in_ready), 1);
    check(!out_valid, 1, "out_valid after mid-frame reset", int'(out_valid), 0);
    send_line(3, -7, 11, 5);

    while (fcnt != nf) @(negedge clk);
    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule